// File: doc/BRIEF.md
# Iterative Shift-Add Multiplier

This block multiplies two 32-bit integers over 32 clock cycles and returns the 64-bit product as a high word and a low word. A one-cycle start request loads both operands and a mode bit that selects signed or unsigned operation. One multiplier bit is retired per clock: a conditional add into the high word and a one-bit right shift of the whole high/low pair happen in the same cycle.

The multiplier operand is held in the low-word register itself. Its bits are consumed at the bottom while product bits enter at the top, so no separate multiplier register exists. A 33-bit adder keeps the carry (unsigned) or the true sign (signed) of each partial sum. That bit becomes the new top bit of the high word after the shift. In signed mode the high word and the multiplicand are sign-extended. The final iteration subtracts the multiplicand instead of adding it, which accounts for the negative weight of the multiplier's top bit.

The surrounding pipeline issues a start while the block is idle, waits for the done pulse, and then reads both halves. The result holds until the next accepted start.

Top module: `seq_mul`

## Requirements
- R1: After reset, busy_o and done_o are 0, and hi_o and lo_o are 0.
- R2: A start_i sampled high while busy_o is 0 sets busy_o in the next cycle. mcand_i, mplier_i and signed_i are captured at that edge, so changing them afterwards has no effect on the result.
- R3: busy_o stays high for exactly 32 cycles. done_o is high for exactly one cycle, the first cycle in which busy_o is low again.
- R4: With signed_i = 0 at start, {hi_o, lo_o} equals the unsigned 64-bit product of the operands when done_o is high.
- R5: With signed_i = 1 at start, {hi_o, lo_o} equals the two's-complement 64-bit product. This includes the most negative value times -1 and times itself.
- R6: A start_i sampled high while busy_o is 1 is ignored. This holds also in the cycle of the last iteration. Neither the result nor the 32-cycle busy length changes.
- R7: While idle and with no start accepted, hi_o and lo_o keep their values.
- R8: done_o and busy_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, honoured only while idle |
| signed_i | input | 1 | 1 = signed multiply, 0 = unsigned |
| mcand_i | input | 32 | Multiplicand |
| mplier_i | input | 32 | Multiplier |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle pulse after the last iteration |
| hi_o | output | 32 | High half of the product |
| lo_o | output | 32 | Low half of the product |

## Verification
A new start request can arrive in the same cycle as the block's last iteration, when it is about to drop busy and pulse done. The bench drives start with different operands at that edge, and also at an edge in mid-run. The run is judged correct only if busy still lasts exactly 32 cycles, done still pulses once, and the product matches the first operand pair. The bench also changes the operand inputs right after every accepted start, so that late operand changes cannot reach the result.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic {
    MODE_UNS = 1'b0,
    MODE_SGN = 1'b1
  } mul_mode_e;
endpackage

// File: rtl/mul_addsub.sv
module mul_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sext_i,
  input  logic         en_i,
  input  logic         sub_i,
  output logic [W:0]   sum_o
);
  logic [W:0] a_ext, b_ext;

  assign a_ext = {sext_i & a_i[W-1], a_i};
  assign b_ext = {sext_i & b_i[W-1], b_i};

  always_comb begin
    if (!en_i)      sum_o = a_ext;
    else if (sub_i) sum_o = a_ext - b_ext;
    else            sum_o = a_ext + b_ext;
  end
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
  parameter int unsigned ITER = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ITER - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign last_o = busy_q & (cnt_q == CNT_LAST);
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_o) busy_q <= 1'b0;
      end
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> busy_q);
  // R3
  last_iter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (done_q && !busy_q));
  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R6
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o) |=> busy_q);
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         last_i,
  input  mul_mode_e    mode_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic [W-1:0] mcand_q, hi_q, lo_q;
  mul_mode_e    mode_q;
  logic [W:0]   sum;
  logic         sgn;

  assign sgn = (mode_q == MODE_SGN);

  mul_addsub #(.W(W)) u_addsub (
    .a_i   (hi_q),
    .b_i   (mcand_q),
    .sext_i(sgn),
    .en_i  (lo_q[0]),
    .sub_i (sgn & last_i),
    .sum_o (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      mode_q  <= MODE_UNS;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      mode_q  <= mode_i;
      hi_q    <= '0;
      lo_q    <= mplier_i;
    end else if (step_i) begin
      // carry/sign enters HI top, sum lsb enters LO top
      hi_q <= sum[W:1];
      lo_q <= {sum[0], lo_q[W-1:1]};
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> ($stable(hi_q) && $stable(lo_q)));
  // R2
  load_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (hi_q == '0 && lo_q == $past(mplier_i)));
  // R6
  no_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> $stable(mcand_q) && $stable(mode_q));
endmodule

// File: rtl/seq_mul.sv
module seq_mul
  import mul_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic load, step, last;
  mul_mode_e mode;

  assign mode = signed_i ? MODE_SGN : MODE_UNS;

  mul_ctrl #(.ITER(W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .last_o (last),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  mul_datapath #(.W(W)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .last_i  (last),
    .mode_i  (mode),
    .mcand_i (mcand_i),
    .mplier_i(mplier_i),
    .hi_o    (hi_o),
    .lo_o    (lo_o)
  );
endmodule

// File: tb/sim_seq_mul.sv
`timescale 1ns/1ps
module sim_seq_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, sgn = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        busy, done;
  logic [31:0] hi, lo;
  int          n_run = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  seq_mul u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .mcand_i(a), .mplier_i(b), .busy_o(busy), .done_o(done),
    .hi_o(hi), .lo_o(lo)
  );

  function automatic logic [63:0] ref_mul(logic [31:0] x, logic [31:0] y, logic s);
    logic signed [63:0] sx, sy;
    if (s) begin
      sx = $signed({{32{x[31]}}, x});
      sy = $signed({{32{y[31]}}, y});
      return 64'(sx * sy);
    end
    return {32'b0, x} * {32'b0, y};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // inj: 0 none, 1 mid-run start, 2 start on last-iteration edge
  task automatic run(logic [31:0] x, logic [31:0] y, logic s, int inj);
    logic [63:0] exp;
    int n;
    exp = ref_mul(x, y, s);
    @(negedge clk);
    a = x; b = y; sgn = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0; a = $urandom; b = $urandom; sgn = ~s;  // R2 capture
    chk("R2 busy after start", 64'(busy), 64'd1);
    n = 1;
    forever begin
      if ((inj == 1 && n == 10) || (inj == 2 && n == 32)) begin
        start = 1'b1; a = $urandom; b = $urandom;
      end
      @(negedge clk);
      start = 1'b0;
      if (!busy) break;
      n++;
    end
    chk("R3 busy length", 64'(n), 64'd32);
    chk("R3 done after busy", 64'(done), 64'd1);
    chk(s ? "R5 signed product" : "R4 unsigned product", {hi, lo}, exp);
    if (inj != 0) chk("R6 start while busy ignored", {hi, lo}, exp);
    @(negedge clk);
    chk("R3 done single pulse", 64'(done), 64'd0);
    chk("R6 no restart", 64'(busy), 64'd0);
    a = $urandom; b = $urandom;
    repeat (3) @(negedge clk);
    chk("R7 result held idle", {hi, lo}, exp);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #5;
    chk("R1 busy reset", 64'(busy), 64'd0);
    chk("R1 done reset", 64'(done), 64'd0);
    chk("R1 hi/lo reset", {hi, lo}, 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run(32'd12, 32'd13, 1'b0, 0);
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 0);
    run(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 0);
    run(32'h8000_0000, 32'h8000_0000, 1'b1, 0);
    run(32'hFFFF_FFFC, 32'hFFFF_FFFD, 1'b1, 0);
    run(32'hFFFF_FFFC, 32'd5, 1'b1, 1);
    run(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 2);
    run(32'd0, 32'h8000_0001, 1'b0, 2);
    for (int i = 0; i < 40; i++)
      run($urandom, $urandom, 1'($urandom), i % 3);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule